// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block gathers message-signaled interrupts posted by PCIe endpoints and folds them into one level-sensitive interrupt toward the host CPU. Every vector shares a single doorbell register. The value written to it is the vector number, and that write latches the vector's pending bit. Vectors are grouped into 32-bit banks. Each bank has a pending-status word and an enable word on a small 32-bit register bus.

Software handles the summary interrupt as follows. It reads the status words one bank at a time and services every set bit in each word. It then acknowledges vectors by writing ones to their status bits. Masking and unmasking are read-modify-write updates of the enable words. Endpoint messages arrive on a dedicated inbound port that the interconnect has already decoded as doorbell writes. A write to the doorbell offset on the register bus rings it in the same way.

Top module: `msi_doorbell_irq`

## Requirements
- R1: A synchronous active-low reset clears every pending bit and every enable bit. It also drives the interrupt output low, so all status and enable reads return zero afterwards.
- R2: An inbound message with data v below 256 sets pending bit v mod 32 of the status word at byte offset 0x80 + 4*(v/32). Several vectors in one word are all visible together.
- R3: A register-bus write to byte offset 0x7C with data v below 256 sets pending bit v in the same way as an inbound message.
- R4: A doorbell value of 256 or more, from either source, changes no pending bit.
- R5: A write to a status word (0x80 to 0x9C) clears each pending bit whose data bit is one. Bits written as zero keep their value.
- R6: The enable words at byte offsets 0xA0 to 0xBC are plain read/write registers. Enable word k, bit i governs vector 32*k + i.
- R7: The interrupt output is high exactly while some vector is both pending and enabled. A masked vector still latches pending state and raises the output once it is enabled.
- R8: When a doorbell and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R9: A read request returns its data on the read-data port, with the read-valid flag high, in the cycle after the request. Reads of the doorbell offset and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| msgValid | input | 1 | Inbound doorbell message strobe |
| msgData | input | 32 | Inbound doorbell data, the vector number |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, one cycle after the request |
| regRdValid | output | 1 | Read data valid |
| irqOut | output | 1 | Summary interrupt, level |

## Verification
The hardest case to reach is an inbound doorbell and a clearing status write that land on the same bit in the same cycle. The clearing write also carries ones for other vectors in that word, so the test shows both that the colliding bit survives and that its neighbours are cleared. The bench sets up this collision deliberately on two separate ports. A long random phase then draws vector numbers from a narrow range, so that such collisions keep recurring. A behavioural reference compares the interrupt level and every read result on every clock.

// File: rtl/msi_pkg.sv
package msi_pkg;
  parameter int NUM_VEC   = 256;
  parameter int WORD_W    = 32;
  parameter int ADDR_W    = 8;
  parameter int DB_BASE   = 'h7C;
  parameter int STAT_BASE = 'h80;
  parameter int EN_BASE   = 'hA0;

  localparam int BANKS  = NUM_VEC / WORD_W;
  localparam int VEC_W  = $clog2(NUM_VEC);
  localparam int BANK_W = $clog2(BANKS);
  localparam int BIT_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_STAT = 2'd1,
    RD_EN   = 2'd2
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              setA;    // inbound message doorbell
    logic [VEC_W-1:0]  idxA;
    logic              setB;    // register-bus doorbell
    logic [VEC_W-1:0]  idxB;
    logic              clrWr;   // write-one-to-clear on a status word
    logic              enWr;    // enable word write
    logic [BANK_W-1:0] bank;
    logic [WORD_W-1:0] data;
    logic              rdEn;
    rdSel_e            rdSel;
    logic [BANK_W-1:0] rdBank;
  } strobe_t;
endpackage

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [WORD_W-1:0] msgData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output strobe_t           strb,
  output logic              rdValid
);
  localparam int BANK_BYTES = 4 * BANKS;

  int   addrInt;
  logic isDb, inStat, inEn;
  logic msgOk, busDbOk;
  logic [BANK_W-1:0] statBank, enBank;

  always_comb begin
    addrInt  = int'(regAddr);
    isDb     = (addrInt >> 2) == (DB_BASE >> 2);
    inStat   = (addrInt >= STAT_BASE) && (addrInt < STAT_BASE + BANK_BYTES);
    inEn     = (addrInt >= EN_BASE) && (addrInt < EN_BASE + BANK_BYTES);
    statBank = BANK_W'((addrInt - STAT_BASE) >> 2);
    enBank   = BANK_W'((addrInt - EN_BASE) >> 2);
    msgOk    = msgData < WORD_W'(NUM_VEC);
    busDbOk  = regWrData < WORD_W'(NUM_VEC);
  end

  always_comb begin
    strb       = '0;
    strb.setA  = msgValid && msgOk;
    strb.idxA  = msgData[VEC_W-1:0];
    strb.setB  = regWrEn && isDb && busDbOk;
    strb.idxB  = regWrData[VEC_W-1:0];
    strb.clrWr = regWrEn && inStat;
    strb.enWr  = regWrEn && inEn;
    strb.bank  = inStat ? statBank : enBank;
    strb.data  = regWrData;
    strb.rdEn  = regRdEn;
    if (inStat) begin
      strb.rdSel  = RD_STAT;
      strb.rdBank = statBank;
    end else if (inEn) begin
      strb.rdSel  = RD_EN;
      strb.rdBank = enBank;
    end else begin
      strb.rdSel  = RD_ZERO;
      strb.rdBank = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= regRdEn;
  end

  AST_RD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> rdValid); // R9
  AST_BIG_VECTOR_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgData >= WORD_W'(NUM_VEC)) |-> !strb.setA); // R4
  AST_BIG_BUS_DB_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData >= WORD_W'(NUM_VEC)) |-> !strb.setB); // R4
endmodule

// File: rtl/msi_dp.sv
module msi_dp
  import msi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  output logic [WORD_W-1:0] rdData,
  output logic              irqOut
);
  logic [BANKS-1:0][WORD_W-1:0] pendBank;
  logic [BANKS-1:0][WORD_W-1:0] enBank;
  logic [NUM_VEC-1:0] pendFlat, enFlat;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] setMask, clrMask;

    always_comb begin
      setMask = '0;
      if (strb.setA && strb.idxA[VEC_W-1:BIT_W] == BANK_W'(b))
        setMask[strb.idxA[BIT_W-1:0]] = 1'b1;
      if (strb.setB && strb.idxB[VEC_W-1:BIT_W] == BANK_W'(b))
        setMask[strb.idxB[BIT_W-1:0]] = 1'b1;
      clrMask = (strb.clrWr && strb.bank == BANK_W'(b)) ? strb.data : '0;
    end

    // set applied after clear: a colliding event survives
    always_ff @(posedge clk) begin
      if (!rstN) pendBank[b] <= '0;
      else       pendBank[b] <= (pendBank[b] & ~clrMask) | setMask;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                                        enBank[b] <= '0;
      else if (strb.enWr && strb.bank == BANK_W'(b))    enBank[b] <= strb.data;
    end
  end

  assign pendFlat = pendBank;
  assign enFlat   = enBank;
  assign irqOut   = |(pendFlat & enFlat);

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdEn) begin
      case (strb.rdSel)
        RD_STAT: rdData <= pendBank[strb.rdBank];
        RD_EN:   rdData <= enBank[strb.rdBank];
        default: rdData <= '0;
      endcase
    end
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pendFlat == '0 && enFlat == '0 && !irqOut)); // R1
  AST_MSG_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setA |=> pendFlat[$past(strb.idxA)]); // R2
  AST_BUS_DB_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setB |=> pendFlat[$past(strb.idxB)]); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrWr && !strb.setA && !strb.setB)
      |=> (pendBank[$past(strb.bank)] & $past(strb.data)) == '0); // R5
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strb.enWr |=> enBank[$past(strb.bank)] == $past(strb.data)); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enFlat == '0) |-> !irqOut); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setA && strb.clrWr && strb.bank == strb.idxA[VEC_W-1:BIT_W]
      && strb.data[strb.idxA[BIT_W-1:0]]) |=> pendFlat[$past(strb.idxA)]); // R8
endmodule

// File: rtl/msi_doorbell_irq.sv
module msi_doorbell_irq
  import msi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              msgValid,
  input  logic [WORD_W-1:0] msgData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              regRdValid,
  output logic              irqOut
);
  strobe_t strb;

  msi_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .msgValid  (msgValid),
    .msgData   (msgData),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb),
    .rdValid   (regRdValid)
  );

  msi_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdData (regRdData),
    .irqOut (irqOut)
  );
endmodule

// File: tb/msi_doorbell_irq_tb.sv
module msi_doorbell_irq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0;
  logic [31:0] msgData = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regRdValid;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk; // 125 MHz

  msi_doorbell_irq u_dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgData(msgData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .irqOut(irqOut)
  );

  // behavioural reference
  logic [255:0] mPend = '0;
  logic [255:0] mEn = '0;
  logic         mRdValid = 1'b0;
  logic [31:0]  mRd = '0;
  bit           armed = 1'b0;

  function automatic logic [31:0] modelRead(input logic [7:0] ad);
    int a = int'(ad);
    if (a >= 'h80 && a < 'hA0) return mPend[((a - 'h80) >> 2) * 32 +: 32];
    if (a >= 'hA0 && a < 'hC0) return mEn[((a - 'hA0) >> 2) * 32 +: 32];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mEn = '0; mRdValid = 1'b0; mRd = '0; armed = 1'b1;
    end else begin
      int a;
      mRdValid = regRdEn;
      if (regRdEn) mRd = modelRead(regAddr);
      a = int'(regAddr);
      if (regWrEn && a >= 'h80 && a < 'hA0)
        for (int i = 0; i < 32; i++)
          if (regWrData[i]) mPend[((a - 'h80) >> 2) * 32 + i] = 1'b0;
      if (regWrEn && a >= 'hA0 && a < 'hC0)
        mEn[((a - 'hA0) >> 2) * 32 +: 32] = regWrData;
      if (msgValid && msgData < 256) mPend[msgData[7:0]] = 1'b1;
      if (regWrEn && (a >> 2) == ('h7C >> 2) && regWrData < 256)
        mPend[regWrData[7:0]] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (armed) begin
      check(irqOut === (|(mPend & mEn)), "R7 irq level",
            {31'd0, irqOut}, {31'd0, |(mPend & mEn)});
      check(regRdValid === mRdValid, "R9 read valid",
            {31'd0, regRdValid}, {31'd0, mRdValid});
      if (mRdValid)
        check(regRdData === mRd, "R2/R6 read data", regRdData, mRd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic sendMsg(input logic [31:0] v);
    @(negedge clk); msgValid = 1'b1; msgData = v;
    @(negedge clk); msgValid = 1'b0;
  endtask

  task automatic wrReg(input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = ad; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdExpect(input logic [7:0] ad, input logic [31:0] exp, input string req);
    @(negedge clk); regRdEn = 1'b1; regAddr = ad;
    @(negedge clk); regRdEn = 1'b0;
    check(regRdValid === 1'b1 && regRdData === exp, req, regRdData, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(irqOut === 1'b0, "R1 irq after reset", {31'd0, irqOut}, 32'd0);
    rdExpect(8'h80, 32'h0, "R1 status zero");
    rdExpect(8'hBC, 32'h0, "R1 enable zero");

    // R2: message doorbells while masked, R7 masked pending stays quiet
    sendMsg(32'd0); sendMsg(32'd31); sendMsg(32'd32); sendMsg(32'd255);
    check(irqOut === 1'b0, "R7 masked pending", {31'd0, irqOut}, 32'd0);
    rdExpect(8'h80, 32'h8000_0001, "R2 word0");
    rdExpect(8'h84, 32'h0000_0001, "R2 word1");
    rdExpect(8'h9C, 32'h8000_0000, "R2 word7");

    // R6 / R7: unmask vector 32 raises the line
    wrReg(8'hA4, 32'h1);
    check(irqOut === 1'b1, "R7 unmask raises", {31'd0, irqOut}, 32'd1);
    rdExpect(8'hA4, 32'h1, "R6 enable readback");

    // R5: zeros keep, ones clear
    wrReg(8'h84, 32'h0);
    rdExpect(8'h84, 32'h1, "R5 zero keeps");
    wrReg(8'h84, 32'h1);
    rdExpect(8'h84, 32'h0, "R5 one clears");
    check(irqOut === 1'b0, "R7 ack drops", {31'd0, irqOut}, 32'd0);

    // R4: out-of-range doorbells ignored
    sendMsg(32'd256); sendMsg(32'hFFFF_FFFF);
    wrReg(8'h7C, 32'd300);
    rdExpect(8'h84, 32'h0, "R4 word1 unchanged");
    rdExpect(8'h80, 32'h8000_0001, "R4 word0 unchanged");
    rdExpect(8'h8C, 32'h0, "R4 word3 unchanged");

    // R3: register-bus doorbell, vector 100 -> word3 bit4
    wrReg(8'h7C, 32'd100);
    rdExpect(8'h8C, 32'h0000_0010, "R3 bus doorbell");

    // R8: message on bit5 and clear of bits 0 and 5 in the same cycle
    @(negedge clk);
    msgValid = 1'b1; msgData = 32'd5;
    regWrEn = 1'b1; regAddr = 8'h80; regWrData = 32'h21;
    @(negedge clk); msgValid = 1'b0; regWrEn = 1'b0;
    rdExpect(8'h80, 32'h8000_0020, "R8 set wins");

    // R9: doorbell and unmapped reads return zero
    rdExpect(8'h7C, 32'h0, "R9 doorbell read");
    rdExpect(8'h40, 32'h0, "R9 unmapped read");

    // R7: vector 255 enabled then acknowledged
    wrReg(8'hBC, 32'h8000_0000);
    check(irqOut === 1'b1, "R7 vector 255", {31'd0, irqOut}, 32'd1);
    wrReg(8'h9C, 32'hFFFF_FFFF);
    check(irqOut === 1'b0, "R7 vector 255 ack", {31'd0, irqOut}, 32'd0);

    // random phase, narrow vector range to provoke collisions
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      msgValid  = ($urandom % 3) == 0;
      msgData   = (($urandom % 16) == 0) ? 32'd256 + ($urandom % 8) : ($urandom % 48);
      regWrEn   = ($urandom % 3) == 0;
      regRdEn   = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: regAddr = 8'h80 + 8'(4 * ($urandom % 2));
        1: regAddr = 8'hA0 + 8'(4 * ($urandom % 2));
        2: regAddr = 8'h7C;
        default: regAddr = 8'h80 + 8'(4 * ($urandom % 16));
      endcase
      regWrData = (regAddr == 8'h7C) ? ($urandom % 64) : $urandom;
    end
    @(negedge clk);
    msgValid = 1'b0; regWrEn = 1'b0; regRdEn = 1'b0;

    // R1: reset mid-run clears everything
    wrReg(8'hA0, 32'hFFFF_FFFF);
    sendMsg(32'd3);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check(irqOut === 1'b0, "R1 irq after reset", {31'd0, irqOut}, 32'd0);
    rdExpect(8'h80, 32'h0, "R1 status cleared");
    rdExpect(8'hA0, 32'h0, "R1 enable cleared");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule